// File: doc/BRIEF.md
# Four-Bank DRAM Command Legality Tracker

This block watches the command stream a controller sends to a four-bank double-data-rate graphics DRAM. It keeps a state for each bank: idle, row open, read burst, write burst or precharging. For each bank it runs cycle counters for activate-to-column delay, activate spacing, burst length, write recovery and precharge. It also tracks a global power mode (running, power-down, self refresh) and a refresh busy window.

The tracker raises a combinational illegal flag for every command that the current state and counters do not permit. An illegal command changes nothing. For every bank it also drives ready vectors, one per command class, so a scheduler can see in advance which commands would be accepted. Row and column values have no effect on legality. Only the bank field and the address bit that carries auto-precharge (for column commands) or all-banks (for precharge) enter the block.

Top module: `bank_cmd_tracker`

## Requirements
- R1: After reset every bank reads idle, the power mode reads running (0), and a no-operation is legal. Bank state codes are: 0 idle, 1 row open, 2 read burst, 3 write burst, 4 precharging. Bank b occupies `bank_state[3b+2:3b]`.
- R2: Operation codes 0 (no-operation) and 1 (deselect) are legal in every state and power mode, and they leave state unchanged.
- R3: Activate (code 2) is legal only on an idle bank, and only when at least T_RC cycles have passed since that bank's previous activate. The bank reads row open in the next cycle.
- R4: Read (code 3) and write (code 4) are legal on a bank that is open or bursting once T_RCD_RD or T_RCD_WR cycles (respectively) have passed since its activate. The bank then shows read or write burst for BURST cycles and returns to row open.
- R5: When `cmd_ap_all` is 1 on a read or write, the command requests auto-precharge. After the burst, the bank precharges for T_RP cycles (read) or T_WR+T_RP cycles (write) and then reads idle. While such a burst runs, every read, write and burst stop is illegal.
- R6: Precharge (code 5) targets `cmd_bank`, or all banks when `cmd_ap_all` is 1. It is illegal on a bank that is precharging, in a write burst, within T_WR cycles after a write burst, or in an auto-precharge read. Idle banks are unaffected. Targeted banks read precharging for T_RP cycles and then read idle.
- R7: A legal read or write to one bank ends any burst in every other bank, which returns to row open.
- R8: Burst stop (code 6) is legal only while a read burst without auto-precharge runs and no bank is writing. The reading bank reads row open in the next cycle.
- R9: Refresh (code 7) is legal only when every bank is idle. For the next T_RFC cycles every command except codes 0 and 1 is illegal.
- R10: Self-refresh entry (code 8) is legal only in running mode with all banks idle, and sets power mode 2. In mode 2 only self-refresh exit (code 9) and codes 0 and 1 are legal. Exit returns the mode to 0.
- R11: Power-down entry (code 10) is legal in running mode when no bank is bursting or precharging, and sets power mode 1. In mode 1 only power-down exit (code 11) and codes 0 and 1 are legal. Exit returns the mode to 0.
- R12: An illegal command, including any code from 12 to 15, changes no bank state and no power mode.
- R13: `act_rdy`, `rd_rdy`, `wr_rdy` and `pre_rdy` bit b, and `sref_rdy`, are 1 exactly when an activate, read, write, single-bank precharge to bank b, or a self-refresh entry (respectively) would be legal in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 4 | Operation code of the command this cycle |
| cmd_bank | input | 2 | Target bank |
| cmd_ap_all | input | 1 | Auto-precharge on read/write; all banks on precharge |
| cmd_illegal | output | 1 | Current command is not permitted |
| bank_state | output | 12 | Three-bit state per bank |
| low_power | output | 2 | 0 running, 1 power-down, 2 self refresh |
| act_rdy | output | 4 | Activate would be legal, per bank |
| rd_rdy | output | 4 | Read would be legal, per bank |
| wr_rdy | output | 4 | Write would be legal, per bank |
| pre_rdy | output | 4 | Single-bank precharge would be legal, per bank |
| sref_rdy | output | 1 | Self-refresh entry would be legal |

## Verification
The bench builds the tracker with T_RCD_RD=3, T_RCD_WR=2, T_RP=3, T_RC=7, T_WR=2, T_RFC=5 and BURST=2. Each window therefore differs from the others and spans only a few cycles. With these values the bench probes both sides of every limit: the cycle before the read delay ends, the write delay one cycle shorter than the read delay, the last recovery cycle that still blocks a precharge, and an activate refused by spacing while the bank is already idle. The auto-precharge write waits five cycles, which keeps it apart from the three-cycle read case.

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker #(
  parameter int T_RCD_RD = 4,
  parameter int T_RCD_WR = 3,
  parameter int T_RP     = 4,
  parameter int T_RC     = 12,
  parameter int T_WR     = 3,
  parameter int T_RFC    = 20,
  parameter int BURST    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cmd_op,
  input  logic [1:0]  cmd_bank,
  input  logic        cmd_ap_all,
  output logic        cmd_illegal,
  output logic [11:0] bank_state,
  output logic [1:0]  low_power,
  output logic [3:0]  act_rdy,
  output logic [3:0]  rd_rdy,
  output logic [3:0]  wr_rdy,
  output logic [3:0]  pre_rdy,
  output logic        sref_rdy
);
  localparam int MAX_A   = (T_RCD_RD > T_RCD_WR) ? T_RCD_RD : T_RCD_WR;
  localparam int AGE_MAX = (T_RC > MAX_A) ? T_RC : (MAX_A > 0 ? MAX_A : 1);
  localparam int CW      = $clog2(AGE_MAX + T_WR + T_RP + T_RFC + BURST + 2);

  localparam logic [3:0] OP_NOP = 4'd0, OP_DES = 4'd1, OP_ACT = 4'd2, OP_RD = 4'd3,
                         OP_WR = 4'd4, OP_PRE = 4'd5, OP_BST = 4'd6, OP_REF = 4'd7,
                         OP_SRI = 4'd8, OP_SRO = 4'd9, OP_PDI = 4'd10, OP_PDO = 4'd11;
  localparam logic [2:0] S_IDLE = 3'd0, S_OPEN = 3'd1, S_RD = 3'd2, S_WR = 3'd3, S_PRE = 3'd4;
  localparam logic [1:0] M_RUN = 2'd0, M_PD = 2'd1, M_SR = 2'd2;

  logic [2:0]    st   [4];
  logic [CW-1:0] age  [4];
  logic [CW-1:0] bcnt [4];
  logic [CW-1:0] pcnt [4];
  logic [CW-1:0] wrc  [4];
  logic [3:0]    ap;
  logic [1:0]    mode;
  logic [CW-1:0] busy;
  logic [3:0]    is_idle, is_rd, is_wr, is_pre, is_open;
  logic          run, any_ap, bst_ok, pd_ok, cmd_ok;

  assign run       = (mode == M_RUN) && (busy == '0);
  assign any_ap    = |ap;
  assign low_power = mode;

  for (genvar b = 0; b < 4; b++) begin : g_bank
    assign is_idle[b] = st[b] == S_IDLE;
    assign is_open[b] = st[b] == S_OPEN;
    assign is_rd[b]   = st[b] == S_RD;
    assign is_wr[b]   = st[b] == S_WR;
    assign is_pre[b]  = st[b] == S_PRE;
    assign bank_state[3*b +: 3] = st[b];
    assign act_rdy[b] = run && is_idle[b] && age[b] >= CW'(T_RC);
    assign rd_rdy[b]  = run && (is_open[b] || is_rd[b] || is_wr[b]) && !any_ap
                        && age[b] >= CW'(T_RCD_RD);
    assign wr_rdy[b]  = run && (is_open[b] || is_rd[b] || is_wr[b]) && !any_ap
                        && age[b] >= CW'(T_RCD_WR);
    assign pre_rdy[b] = run && (is_idle[b] || (is_open[b] && wrc[b] == '0)
                        || (is_rd[b] && !ap[b]));
  end

  assign bst_ok   = run && (|is_rd) && !(|is_wr) && !any_ap;
  assign pd_ok    = run && !(|is_rd) && !(|is_wr) && !(|is_pre);
  assign sref_rdy = run && (&is_idle);

  always_comb begin
    case (cmd_op)
      OP_NOP, OP_DES: cmd_ok = 1'b1;
      OP_ACT:         cmd_ok = act_rdy[cmd_bank];
      OP_RD:          cmd_ok = rd_rdy[cmd_bank];
      OP_WR:          cmd_ok = wr_rdy[cmd_bank];
      OP_PRE:         cmd_ok = cmd_ap_all ? (&pre_rdy) : pre_rdy[cmd_bank];
      OP_BST:         cmd_ok = bst_ok;
      OP_REF, OP_SRI: cmd_ok = sref_rdy;
      OP_SRO:         cmd_ok = mode == M_SR;
      OP_PDI:         cmd_ok = pd_ok;
      OP_PDO:         cmd_ok = mode == M_PD;
      default:        cmd_ok = 1'b0;
    endcase
  end
  assign cmd_illegal = !cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        st[b]   <= S_IDLE;
        age[b]  <= CW'(AGE_MAX);
        bcnt[b] <= '0;
        pcnt[b] <= '0;
        wrc[b]  <= '0;
      end
      ap   <= '0;
      mode <= M_RUN;
      busy <= '0;
    end else begin
      if (busy != '0) busy <= busy - 1'b1;
      for (int b = 0; b < 4; b++) begin
        if (age[b] < CW'(AGE_MAX)) age[b] <= age[b] + 1'b1;
        if (wrc[b] != '0) wrc[b] <= wrc[b] - 1'b1;
        case (st[b])
          S_RD, S_WR: begin
            if (bcnt[b] > CW'(1)) bcnt[b] <= bcnt[b] - 1'b1;
            else begin
              ap[b] <= 1'b0;
              if (ap[b]) begin
                st[b]   <= S_PRE;
                pcnt[b] <= is_wr[b] ? CW'(T_WR + T_RP) : CW'(T_RP);
              end else begin
                st[b] <= S_OPEN;
                if (is_wr[b]) wrc[b] <= CW'(T_WR);
              end
            end
          end
          S_PRE: begin
            if (pcnt[b] > CW'(1)) pcnt[b] <= pcnt[b] - 1'b1;
            else st[b] <= S_IDLE;
          end
          default: ;
        endcase
        if (cmd_ok) begin
          case (cmd_op)
            OP_ACT: if (cmd_bank == 2'(b)) begin
              st[b]  <= S_OPEN;
              age[b] <= CW'(1);
            end
            OP_RD, OP_WR: begin
              if (cmd_bank == 2'(b)) begin
                st[b]   <= (cmd_op == OP_RD) ? S_RD : S_WR;
                bcnt[b] <= CW'(BURST);
                ap[b]   <= cmd_ap_all;
              end else if (is_rd[b] || is_wr[b]) begin
                st[b]   <= S_OPEN;
                bcnt[b] <= '0;
                if (is_wr[b]) wrc[b] <= CW'(T_WR);
              end
            end
            OP_PRE: if ((cmd_ap_all || cmd_bank == 2'(b)) && !is_idle[b]) begin
              st[b]   <= S_PRE;
              pcnt[b] <= CW'(T_RP);
              bcnt[b] <= '0;
            end
            OP_BST: if (is_rd[b]) begin
              st[b]   <= S_OPEN;
              bcnt[b] <= '0;
            end
            default: ;
          endcase
        end
      end
      if (cmd_ok) begin
        case (cmd_op)
          OP_REF:         busy <= CW'(T_RFC);
          OP_SRI:         mode <= M_SR;
          OP_PDI:         mode <= M_PD;
          OP_SRO, OP_PDO: mode <= M_RUN;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bank_cmd_tracker_chk.sv
module bank_cmd_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cmd_op,
  input logic [1:0]  cmd_bank,
  input logic        cmd_ap_all,
  input logic        cmd_illegal,
  input logic [11:0] bank_state,
  input logic [1:0]  low_power,
  input logic [3:0]  act_rdy,
  input logic [3:0]  rd_rdy,
  input logic [3:0]  wr_rdy,
  input logic [3:0]  pre_rdy,
  input logic        sref_rdy
);
  logic [3:0] in_wr, in_pre;

  for (genvar b = 0; b < 4; b++) begin : g_c
    assign in_wr[b]  = bank_state[3*b +: 3] == 3'd3;
    assign in_pre[b] = bank_state[3*b +: 3] == 3'd4;

    // R3
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 4'd2 && cmd_bank == 2'(b) && !cmd_illegal) |=> bank_state[3*b +: 3] == 3'd1);

    // R6
    pre_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pre[b] && cmd_op == 4'd2 && cmd_bank == 2'(b)) |-> cmd_illegal);

    // R13
    col_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rdy[b] || wr_rdy[b]) |-> (bank_state[3*b +: 3] inside {3'd1, 3'd2, 3'd3}));

    // R13
    act_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_rdy[b] |-> (bank_state[3*b +: 3] == 3'd0 && low_power == 2'd0));

    // R13
    pre_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_rdy[b] |-> !in_pre[b] && !in_wr[b]);
  end

  // R2
  nop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 4'd0 || cmd_op == 4'd1) |-> !cmd_illegal);

  // R8
  bst_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 4'd6 && (|in_wr)) |-> cmd_illegal);

  // R6
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 4'd5 && cmd_ap_all && (|in_pre)) |-> cmd_illegal);

  // R10
  sref_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 4'd8 && !cmd_illegal) |=> low_power == 2'd2);

  // R10
  sref_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sref_rdy |-> (low_power == 2'd0 && bank_state == 12'd0));
endmodule

bind bank_cmd_tracker bank_cmd_tracker_chk u_chk (.*);

// File: tb/sim_bank_cmd_tracker.sv
`timescale 1ns/1ps
module sim_bank_cmd_tracker;
  localparam int NOP = 0, DES = 1, ACT = 2, RD = 3, WR = 4, PRE = 5, BST = 6,
                 REF = 7, SRI = 8, SRO = 9, PDI = 10, PDO = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_bank = '0;
  logic        cmd_ap_all = 1'b0;
  logic        cmd_illegal;
  logic [11:0] bank_state;
  logic [1:0]  low_power;
  logic [3:0]  act_rdy, rd_rdy, wr_rdy, pre_rdy;
  logic        sref_rdy;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  bank_cmd_tracker #(.T_RCD_RD(3), .T_RCD_WR(2), .T_RP(3), .T_RC(7), .T_WR(2),
                     .T_RFC(5), .BURST(2)) u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int st(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  task automatic cmd(input int op, input int bank, input int flag, input int exp_ill,
                     input string tag);
    @(negedge clk);
    cmd_op = 4'(op); cmd_bank = 2'(bank); cmd_ap_all = flag[0];
    #2;
    check(tag, int'(cmd_illegal), exp_ill);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_op = 4'(NOP); cmd_bank = '0; cmd_ap_all = 1'b0;
      #2;
    end
  endtask

  task automatic t_reset;
    idle(1);
    check("R1 all idle", int'(bank_state), 0);
    check("R1 running", int'(low_power), 0);
    check("R1 nop legal", int'(cmd_illegal), 0);
    check("R13 act_rdy", int'(act_rdy), 15);
    check("R13 rd_rdy", int'(rd_rdy), 0);
    check("R13 sref_rdy", int'(sref_rdy), 1);
  endtask

  task automatic t_act_timing;
    cmd(ACT, 0, 0, 0, "R3 activate");
    cmd(RD, 0, 0, 1, "R4 read early");
    check("R3 open", st(0), 1);
    idle(1);
    check("R13 rd not ready", int'(rd_rdy[0]), 0);
    check("R13 wr ready", int'(wr_rdy[0]), 1);
    cmd(RD, 0, 0, 0, "R4 read on time");
    idle(1); check("R4 burst c1", st(0), 2);
    idle(1); check("R4 burst c2", st(0), 2);
    idle(1); check("R4 burst end", st(0), 1);
    cmd(PRE, 0, 0, 0, "R6 precharge");
    cmd(ACT, 0, 0, 1, "R6 act while precharging");
    check("R12 state kept", st(0), 4);
    idle(2); check("R6 still precharging", st(0), 4);
    cmd(ACT, 0, 0, 0, "R3 act after precharge");
    cmd(PRE, 0, 0, 0, "R6 precharge again");
    idle(3); check("R6 precharge window", st(0), 4);
    cmd(ACT, 0, 0, 1, "R3 act spacing 5");
    check("R6 idle after window", st(0), 0);
    cmd(ACT, 0, 0, 1, "R3 act spacing 6");
    cmd(ACT, 0, 0, 0, "R3 act spacing 7");
    idle(1); check("R3 open again", st(0), 1);
    cmd(PRE, 0, 0, 0, "R6 close");
    idle(11);
  endtask

  task automatic t_ap_read;
    cmd(ACT, 1, 0, 0, "R3 activate b1");
    idle(2);
    cmd(RD, 1, 1, 0, "R5 read autoprecharge");
    cmd(BST, 0, 0, 1, "R8 stop on ap read");
    cmd(RD, 1, 0, 1, "R5 read during ap");
    check("R12 burst kept", st(1), 2);
    idle(1); check("R5 precharge after read", st(1), 4);
    idle(2); check("R5 precharge held", st(1), 4);
    idle(1); check("R5 idle after ap", st(1), 0);
    idle(8);
  endtask

  task automatic t_write;
    cmd(ACT, 2, 0, 0, "R3 activate b2");
    idle(1);
    cmd(WR, 2, 0, 0, "R4 write on time");
    cmd(BST, 0, 0, 1, "R8 stop during write");
    cmd(PRE, 2, 0, 1, "R6 pre during write");
    check("R4 write burst", st(2), 3);
    idle(1);
    check("R4 write end", st(2), 1);
    check("R6 recovery not ready", int'(pre_rdy[2]), 0);
    cmd(PRE, 2, 0, 1, "R6 pre in recovery");
    cmd(PRE, 2, 0, 0, "R6 pre after recovery");
    idle(3); idle(1); check("R6 idle b2", st(2), 0);
    cmd(ACT, 3, 0, 0, "R3 activate b3");
    idle(1);
    cmd(WR, 3, 1, 0, "R5 write autoprecharge");
    idle(2); check("R5 write burst", st(3), 3);
    idle(5); check("R5 write recovery+precharge", st(3), 4);
    idle(1); check("R5 idle after ap write", st(3), 0);
    idle(8);
  endtask

  task automatic t_cut;
    cmd(ACT, 0, 0, 0, "R3 activate b0");
    cmd(ACT, 1, 0, 0, "R3 activate b1");
    idle(2);
    cmd(RD, 0, 0, 0, "R4 read b0");
    cmd(RD, 1, 0, 0, "R7 read b1");
    cmd(BST, 0, 0, 0, "R8 stop read");
    check("R7 b0 cut", st(0), 1);
    check("R7 b1 reading", st(1), 2);
    idle(1); check("R8 b1 stopped", st(1), 1);
    cmd(PRE, 0, 1, 0, "R6 precharge all");
    idle(1);
    check("R6 all b0", st(0), 4);
    check("R6 all b1", st(1), 4);
    check("R6 idle bank untouched", st(2), 0);
    idle(3);
    check("R6 all idle", int'(bank_state), 0);
    idle(8);
  endtask

  task automatic t_refresh;
    cmd(ACT, 0, 0, 0, "R3 activate");
    idle(1);
    cmd(PRE, 0, 0, 0, "R6 precharge");
    cmd(PRE, 0, 1, 1, "R6 all while precharging");
    check("R13 sref not ready", int'(sref_rdy), 0);
    idle(3);
    check("R6 idle", st(0), 0);
    check("R13 sref ready", int'(sref_rdy), 1);
    cmd(REF, 0, 0, 0, "R9 refresh");
    cmd(ACT, 0, 0, 1, "R9 act during refresh");
    idle(3);
    cmd(ACT, 0, 0, 1, "R9 act last refresh cycle");
    cmd(ACT, 0, 0, 0, "R9 act after refresh");
    cmd(PRE, 0, 0, 0, "R6 close");
    idle(11);
  endtask

  task automatic t_power;
    cmd(PDI, 0, 0, 0, "R11 power-down entry");
    cmd(ACT, 0, 0, 1, "R11 act in power-down");
    check("R11 mode", int'(low_power), 1);
    cmd(NOP, 0, 0, 0, "R2 nop in power-down");
    cmd(PDO, 0, 0, 0, "R11 exit");
    idle(1); check("R11 running", int'(low_power), 0);
    cmd(SRI, 0, 0, 0, "R10 self refresh entry");
    cmd(PDO, 0, 0, 1, "R10 wrong exit");
    check("R10 mode", int'(low_power), 2);
    cmd(REF, 0, 0, 1, "R10 refresh in self refresh");
    check("R12 mode kept", int'(low_power), 2);
    cmd(DES, 0, 0, 0, "R2 deselect");
    check("R13 no act ready", int'(act_rdy), 0);
    cmd(SRO, 0, 0, 0, "R10 exit");
    idle(1); check("R10 running", int'(low_power), 0);
    cmd(ACT, 0, 0, 0, "R3 activate");
    cmd(SRI, 0, 0, 1, "R10 entry with open bank");
    cmd(PDI, 0, 0, 0, "R11 entry with open bank");
    idle(1); check("R11 mode open bank", int'(low_power), 1);
    check("R2 bank kept", st(0), 1);
    cmd(PDO, 0, 0, 0, "R11 exit again");
    cmd(PRE, 0, 0, 0, "R6 close");
    idle(11);
    cmd(15, 0, 0, 1, "R12 unknown code");
    cmd(12, 1, 1, 1, "R12 unknown code 12");
    idle(1);
    check("R12 banks unchanged", int'(bank_state), 0);
    check("R12 mode unchanged", int'(low_power), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_act_timing();
    t_ap_read();
    t_write();
    t_cut();
    t_refresh();
    t_power();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule